// File: doc/BRIEF.md
# Display mode register sanitizer

This block holds the mode registers of a linear-framebuffer display controller. Software reaches it through two write strobes sharing one data bus: one strobe loads a register index, the other writes the selected register. The set covers horizontal and vertical resolution, colour depth, virtual width, virtual height and the X/Y pan offsets, plus an enable bit. A read port always shows the register chosen by the current index.

No write is ever refused. While the mode is enabled, every geometry write starts a pass that checks all registers together, because one value can narrow the legal range of another. Each register is coerced to the nearest legal value that fits the video memory. The pass then derives the scanline pitch in bytes and the display start address in 32-bit words. A sequential divider finds how many lines fit in memory, and a busy flag is raised while the pass runs. A one-cycle strobe marks every change of the derived outputs.

Top module: `dispmode_sanitizer`

## Requirements
- R1: While the enable bit is 0, a data write stores the written value unchanged in the selected geometry register, and the pitch, start address and strobe outputs do not change.
- R2: During a pass, a colour depth of 4, 8, 16, 24 or 32 is kept. A depth of 15 is kept in the register but counts as 16 bits per pixel. Any other depth is replaced by 8.
- R3: During a pass, the horizontal resolution has bits [2:0] cleared. A zero result becomes 8, and a result above MAX_X becomes MAX_X.
- R4: During a pass, the virtual width has bits [2:0] cleared and is limited to MAX_X. If it is then below the horizontal resolution, it is raised to that resolution.
- R5: The line length is virtual width × bits per pixel / 8, and the line count is MEM_BYTES / line length. At the end of a pass the virtual height register (index 5) holds the line count, saturated at 65535. Data writes to index 5 are ignored.
- R6: During a pass, a vertical resolution of 0 becomes 1. The result is then limited to MAX_Y and then to the line count.
- R7: During a pass, the X offset is limited to MAX_X and the Y offset to MAX_Y.
- R8: The byte offset is X offset × bits / 8 + Y offset × line length. If the byte offset plus vertical resolution × line length is greater than MEM_BYTES, the Y offset is cleared and the offset recomputed. If the sum is still too large, the X offset is cleared too and the offset becomes 0. The pitch output is then the line length and the start output is the byte offset / 4.
- R9: upd_o is high for exactly one cycle, the cycle in which pitch_o or start_o has just taken a different value. It stays low at all other times.
- R10: Writing index 0 with bit 0 set while the mode is disabled clears the virtual width and both offsets, sets the enable bit and runs a pass. Writing bit 0 set while already enabled changes no register and runs no pass. Writing bit 0 clear disables the mode.
- R11: busy_o is high from the cycle after a pass-starting write until the pass finishes. Data writes made while busy_o is high are ignored.
- R12: After reset, every register reads 0, pitch_o and start_o are 0, and busy_o and upd_o are low.
- R13: The register map is: 0 enable (bit 0), 1 horizontal resolution, 2 vertical resolution, 3 colour depth, 4 virtual width, 5 virtual height, 6 X offset, 7 Y offset. An index write takes the index from wdata_i[2:0]. rdata_o shows the register at the current index, with enable in bit 0 and the other bits 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idx_wr_i | input | 1 | Load register index from wdata_i[2:0] |
| dat_wr_i | input | 1 | Write wdata_i to the indexed register |
| wdata_i | input | 16 | Write data for both strobes |
| rdata_o | output | 16 | Value of the indexed register |
| busy_o | output | 1 | Sanitization pass in progress |
| pitch_o | output | LW | Scanline pitch in bytes |
| start_o | output | MW | Display start address in 32-bit words |
| upd_o | output | 1 | One-cycle pulse when pitch_o or start_o changes |

## Verification
The bench builds the block with MAX_X = 64, MAX_Y = 48 and MEM_BYTES = 4096. With a memory this small, the line count drops below the resolution limits at moderate widths and depths, so both the MAX_Y clamp and the line-count clamp on the vertical resolution can be reached. The same settings make both stages of the offset fallback reachable, including a frame that fills the memory exactly. Every depth class is driven against these limits, including 4 bits per pixel with an odd X offset, where the byte offset truncates.

// File: rtl/dispmode_pkg.sv
package dispmode_pkg;
  localparam int unsigned REG_W = 16;

  localparam logic [2:0] IX_EN    = 3'd0;
  localparam logic [2:0] IX_XRES  = 3'd1;
  localparam logic [2:0] IX_YRES  = 3'd2;
  localparam logic [2:0] IX_DEPTH = 3'd3;
  localparam logic [2:0] IX_VW    = 3'd4;
  localparam logic [2:0] IX_VH    = 3'd5;
  localparam logic [2:0] IX_XOFF  = 3'd6;
  localparam logic [2:0] IX_YOFF  = 3'd7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FIX, ST_DIV, ST_YRES, ST_OFS
  } dm_state_e;

  typedef struct packed {
    logic [REG_W-1:0] xres;
    logic [REG_W-1:0] yres;
    logic [REG_W-1:0] depth;
    logic [REG_W-1:0] vw;
    logic [REG_W-1:0] xoff;
    logic [REG_W-1:0] yoff;
  } dm_geom_t;
endpackage

// File: rtl/dispmode_fix.sv
module dispmode_fix
  import dispmode_pkg::*;
#(
  parameter int unsigned MAX_X = 1600,
  parameter int unsigned MAX_Y = 1200,
  parameter int unsigned LW    = 13
) (
  input  dm_geom_t          g_i,
  output dm_geom_t          g_o,
  output logic [5:0]        bits_o,
  output logic [LW-1:0]     ll_o
);
  localparam logic [REG_W-1:0] MAXX = REG_W'(MAX_X);
  localparam logic [REG_W-1:0] MAXY = REG_W'(MAX_Y);

  always_comb begin
    g_o = g_i;
    case (g_i.depth)
      16'd4, 16'd8, 16'd16, 16'd24, 16'd32: bits_o = g_i.depth[5:0];
      16'd15:  bits_o = 6'd16;
      default: begin
        bits_o    = 6'd8;
        g_o.depth = 16'd8;
      end
    endcase

    g_o.xres = g_i.xres & ~16'd7;
    if (g_o.xres == '0) g_o.xres = 16'd8;
    if (g_o.xres > MAXX) g_o.xres = MAXX;

    g_o.vw = g_i.vw & ~16'd7;
    if (g_o.vw > MAXX) g_o.vw = MAXX;
    if (g_o.vw < g_o.xres) g_o.vw = g_o.xres;

    if (g_i.xoff > MAXX) g_o.xoff = MAXX;
    if (g_i.yoff > MAXY) g_o.yoff = MAXY;

    // vw is a multiple of 8, so the division is exact
    ll_o = LW'((32'(g_o.vw) >> 3) * 32'(bits_o));
  end
endmodule

// File: rtl/dispmode_div.sv
module dispmode_div #(
  parameter int unsigned NW = 24,
  parameter int unsigned DW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [NW-1:0] num_i,
  input  logic [DW-1:0] den_i,
  output logic [NW-1:0] quo_o,
  output logic          done_o
);
  localparam int unsigned CW = $clog2(NW + 1);

  logic [CW-1:0] cnt_q;
  logic [DW:0]   rem_q, rem_sh;
  logic [DW-1:0] den_q;
  logic [NW-1:0] q_q;
  logic          ge;

  assign rem_sh = {rem_q[DW-1:0], q_q[NW-1]};
  assign ge     = rem_sh >= {1'b0, den_q};
  assign quo_o  = q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      q_q    <= '0;
      done_o <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= CW'(NW);
      rem_q  <= '0;
      den_q  <= den_i;
      q_q    <= num_i;
      done_o <= 1'b0;
    end else if (cnt_q != '0) begin
      rem_q  <= ge ? rem_sh - {1'b0, den_q} : rem_sh;
      q_q    <= {q_q[NW-2:0], ge};
      cnt_q  <= cnt_q - 1'b1;
      done_o <= (cnt_q == CW'(1));
    end else begin
      done_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dispmode_ofs.sv
module dispmode_ofs
  import dispmode_pkg::*;
#(
  parameter int unsigned LW        = 13,
  parameter int unsigned AW        = 26,
  parameter int unsigned MEM_BYTES = 8388608
) (
  input  logic [5:0]       bits_i,
  input  logic [REG_W-1:0] xoff_i,
  input  logic [REG_W-1:0] yoff_i,
  input  logic [REG_W-1:0] yres_i,
  input  logic [LW-1:0]    ll_i,
  output logic [REG_W-1:0] xoff_o,
  output logic [REG_W-1:0] yoff_o,
  output logic [AW-1:0]    off_o
);
  localparam logic [AW-1:0] MEMA = AW'(MEM_BYTES);

  logic [AW-1:0] xb, span, full;

  always_comb begin
    xb     = (AW'(xoff_i) * AW'(bits_i)) >> 3;
    span   = AW'(yres_i) * AW'(ll_i);
    full   = xb + AW'(yoff_i) * AW'(ll_i);
    xoff_o = xoff_i;
    yoff_o = yoff_i;
    off_o  = full;
    if (full + span > MEMA) begin
      yoff_o = '0;
      off_o  = xb;
      if (xb + span > MEMA) begin
        xoff_o = '0;
        off_o  = '0;
      end
    end
  end
endmodule

// File: rtl/dispmode_sanitizer.sv
module dispmode_sanitizer
  import dispmode_pkg::*;
#(
  parameter int unsigned MAX_X     = 1600,
  parameter int unsigned MAX_Y     = 1200,
  parameter int unsigned MEM_BYTES = 8388608,
  localparam int unsigned LW  = $clog2(MAX_X * 4 + 1),
  localparam int unsigned MW  = $clog2(MEM_BYTES + 1),
  localparam int unsigned AW0 = LW + $clog2(MAX_Y + 1) + 2,
  localparam int unsigned AW  = (AW0 > MW + 1) ? AW0 : MW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idx_wr_i,
  input  logic             dat_wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             busy_o,
  output logic [LW-1:0]    pitch_o,
  output logic [MW-1:0]    start_o,
  output logic             upd_o
);
  localparam logic [REG_W-1:0] MAXY = REG_W'(MAX_Y);

  dm_state_e        st_q;
  logic             en_q;
  logic [2:0]       idx_q;
  dm_geom_t         g_q, g_fix;
  logic [REG_W-1:0] vh_q, vh_sat, y_fix, xoff_n, yoff_n;
  logic [5:0]       bits_fix, bits_q;
  logic [LW-1:0]    ll_fix, ll_q;
  logic [MW-1:0]    maxy_q, quo, start_n;
  logic [AW-1:0]    off_n;
  logic             div_done;

  dispmode_fix #(.MAX_X(MAX_X), .MAX_Y(MAX_Y), .LW(LW)) u_fix (
    .g_i(g_q), .g_o(g_fix), .bits_o(bits_fix), .ll_o(ll_fix)
  );

  dispmode_div #(.NW(MW), .DW(LW)) u_div (
    .clk_i, .rst_ni,
    .start_i(st_q == ST_FIX),
    .num_i(MW'(MEM_BYTES)),
    .den_i(ll_fix),
    .quo_o(quo),
    .done_o(div_done)
  );

  dispmode_ofs #(.LW(LW), .AW(AW), .MEM_BYTES(MEM_BYTES)) u_ofs (
    .bits_i(bits_q), .xoff_i(g_q.xoff), .yoff_i(g_q.yoff), .yres_i(g_q.yres),
    .ll_i(ll_q), .xoff_o(xoff_n), .yoff_o(yoff_n), .off_o(off_n)
  );

  always_comb begin
    y_fix = g_q.yres;
    if (y_fix == '0) y_fix = 16'd1;
    if (y_fix > MAXY) y_fix = MAXY;
    if (32'(y_fix) > 32'(maxy_q)) y_fix = REG_W'(maxy_q);
    vh_sat  = (32'(maxy_q) > 32'd65535) ? 16'hFFFF : REG_W'(maxy_q);
    start_n = MW'(off_n >> 2);
  end

  assign busy_o = (st_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      en_q    <= 1'b0;
      idx_q   <= '0;
      g_q     <= '0;
      vh_q    <= '0;
      bits_q  <= '0;
      ll_q    <= '0;
      maxy_q  <= '0;
      pitch_o <= '0;
      start_o <= '0;
      upd_o   <= 1'b0;
    end else begin
      upd_o <= 1'b0;
      if (idx_wr_i) idx_q <= wdata_i[2:0];
      case (st_q)
        ST_IDLE: if (dat_wr_i) begin
          case (idx_q)
            IX_EN: begin
              if (wdata_i[0] && !en_q) begin
                g_q.vw   <= '0;
                g_q.xoff <= '0;
                g_q.yoff <= '0;
                st_q     <= ST_FIX;
              end
              en_q <= wdata_i[0];
            end
            IX_VH: ;
            default: begin
              case (idx_q)
                IX_XRES:  g_q.xres  <= wdata_i;
                IX_YRES:  g_q.yres  <= wdata_i;
                IX_DEPTH: g_q.depth <= wdata_i;
                IX_VW:    g_q.vw    <= wdata_i;
                IX_XOFF:  g_q.xoff  <= wdata_i;
                default:  g_q.yoff  <= wdata_i;
              endcase
              if (en_q) st_q <= ST_FIX;
            end
          endcase
        end
        ST_FIX: begin
          g_q    <= g_fix;
          bits_q <= bits_fix;
          ll_q   <= ll_fix;
          st_q   <= ST_DIV;
        end
        ST_DIV: if (div_done) begin
          maxy_q <= quo;
          st_q   <= ST_YRES;
        end
        ST_YRES: begin
          g_q.yres <= y_fix;
          st_q     <= ST_OFS;
        end
        default: begin
          g_q.xoff <= xoff_n;
          g_q.yoff <= yoff_n;
          vh_q     <= vh_sat;
          pitch_o  <= ll_q;
          start_o  <= start_n;
          upd_o    <= (ll_q != pitch_o) || (start_n != start_o);
          st_q     <= ST_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    case (idx_q)
      IX_EN:    rdata_o = {15'd0, en_q};
      IX_XRES:  rdata_o = g_q.xres;
      IX_YRES:  rdata_o = g_q.yres;
      IX_DEPTH: rdata_o = g_q.depth;
      IX_VW:    rdata_o = g_q.vw;
      IX_VH:    rdata_o = vh_q;
      IX_XOFF:  rdata_o = g_q.xoff;
      default:  rdata_o = g_q.yoff;
    endcase
  end
endmodule

// File: rtl/dispmode_sanitizer_chk.sv
module dispmode_sanitizer_chk #(
  parameter int unsigned MAX_X     = 1600,
  parameter int unsigned MAX_Y     = 1200,
  parameter int unsigned MEM_BYTES = 8388608,
  localparam int unsigned LW = $clog2(MAX_X * 4 + 1),
  localparam int unsigned MW = $clog2(MEM_BYTES + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          busy_i,
  input logic          upd_i,
  input logic [LW-1:0] pitch_i,
  input logic [MW-1:0] start_i,
  input logic [15:0]   depth_i,
  input logic [15:0]   xres_i,
  input logic [15:0]   vw_i,
  input logic [15:0]   yres_i
);
  logic settled;
  assign settled = en_i && !busy_i;

  p_upd_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |-> !busy_i);

  p_out_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |-> ($stable(pitch_i) && $stable(start_i)));

  p_depth_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settled |-> (depth_i == 16'd4 || depth_i == 16'd8 || depth_i == 16'd15 ||
                 depth_i == 16'd16 || depth_i == 16'd24 || depth_i == 16'd32));

  p_xres_legal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settled |-> (xres_i[2:0] == 3'd0 && xres_i != 16'd0 && 32'(xres_i) <= MAX_X));

  p_vw_cover_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settled |-> (vw_i >= xres_i && 32'(vw_i) <= MAX_X));

  p_yres_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settled |-> (yres_i != 16'd0 && 32'(yres_i) <= MAX_Y));

  p_frame_fits_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settled |-> (48'(start_i) * 48'd4 + 48'(yres_i) * 48'(pitch_i) <= 48'(MEM_BYTES)));

  p_busy_ends_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> (en_i && pitch_i != '0));
endmodule

bind dispmode_sanitizer dispmode_sanitizer_chk #(
  .MAX_X(MAX_X), .MAX_Y(MAX_Y), .MEM_BYTES(MEM_BYTES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_q), .busy_i(busy_o), .upd_i(upd_o),
  .pitch_i(pitch_o), .start_i(start_o), .depth_i(g_q.depth), .xres_i(g_q.xres),
  .vw_i(g_q.vw), .yres_i(g_q.yres)
);

// File: tb/dispmode_sanitizer_bench.sv
`timescale 1ns/1ps
module dispmode_sanitizer_bench;
  localparam int unsigned MAX_X = 64;
  localparam int unsigned MAX_Y = 48;
  localparam int unsigned MEM   = 4096;
  localparam int unsigned LW    = $clog2(MAX_X * 4 + 1);
  localparam int unsigned MW    = $clog2(MEM + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          idx_wr = 1'b0, dat_wr = 1'b0;
  logic [15:0]   wdata = '0;
  logic [15:0]   rdata;
  logic          busy, upd;
  logic [LW-1:0] pitch;
  logic [MW-1:0] start;

  dispmode_sanitizer #(.MAX_X(MAX_X), .MAX_Y(MAX_Y), .MEM_BYTES(MEM)) u_dispmode_sanitizer (
    .clk_i(clk), .rst_ni(rst_n), .idx_wr_i(idx_wr), .dat_wr_i(dat_wr), .wdata_i(wdata),
    .rdata_o(rdata), .busy_o(busy), .pitch_o(pitch), .start_o(start), .upd_o(upd)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [63:0] exp_q[$];
  int m[8];          // model registers, index 0 holds the enable bit
  int m_pitch = 0, m_start = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_pass();
    int bits, ll, maxy, off;
    case (m[3])
      4, 8, 16, 24, 32: bits = m[3];
      15: bits = 16;
      default: begin bits = 8; m[3] = 8; end
    endcase
    m[1] = m[1] & 'hFFF8;
    if (m[1] == 0) m[1] = 8;
    if (m[1] > MAX_X) m[1] = MAX_X;
    m[4] = m[4] & 'hFFF8;
    if (m[4] > MAX_X) m[4] = MAX_X;
    if (m[4] < m[1]) m[4] = m[1];
    if (m[6] > MAX_X) m[6] = MAX_X;
    if (m[7] > MAX_Y) m[7] = MAX_Y;
    ll = m[4] * bits / 8;
    maxy = MEM / ll;
    if (m[2] == 0) m[2] = 1;
    if (m[2] > MAX_Y) m[2] = MAX_Y;
    if (m[2] > maxy) m[2] = maxy;
    off = m[6] * bits / 8 + m[7] * ll;
    if (off + m[2] * ll > MEM) begin
      m[7] = 0;
      off = m[6] * bits / 8;
      if (off + m[2] * ll > MEM) begin
        m[6] = 0;
        off = 0;
      end
    end
    m[5] = (maxy > 65535) ? 65535 : maxy;
    if (ll != m_pitch || off / 4 != m_start) exp_q.push_back({32'(ll), 32'(off / 4)});
    m_pitch = ll;
    m_start = off / 4;
  endtask

  task automatic model_write(int idx, int val);
    val = val & 'hFFFF;
    if (idx == 0) begin
      if ((val & 1) != 0 && m[0] == 0) begin
        m[4] = 0; m[6] = 0; m[7] = 0; m[0] = 1;
        model_pass();
      end else m[0] = val & 1;
    end else if (idx != 5) begin
      m[idx] = val;
      if (m[0] != 0) model_pass();
    end
  endtask

  task automatic set_idx(int idx);
    @(negedge clk); idx_wr = 1'b1; wdata = 16'(idx);
    @(negedge clk); idx_wr = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic check_all(string tag);
    for (int i = 0; i < 8; i++) begin
      set_idx(i);
      #1 chk($sformatf("%s R13 reg%0d", tag, i), int'(rdata), m[i]);
    end
    chk({tag, " pitch"}, int'(pitch), m_pitch);
    chk({tag, " start"}, int'(start), m_start);
  endtask

  task automatic wr(int idx, int val, string tag);
    set_idx(idx);
    dat_wr = 1'b1; wdata = 16'(val);
    model_write(idx, val);
    @(negedge clk); dat_wr = 1'b0;
    wait_idle();
    check_all(tag);
  endtask

  task automatic wr_busy(int idx, int v1, int v2, string tag);
    set_idx(idx);
    dat_wr = 1'b1; wdata = 16'(v1);
    model_write(idx, v1);
    @(negedge clk);
    chk({tag, " busy raised"}, int'(busy), 1);
    wdata = 16'(v2);
    @(negedge clk); dat_wr = 1'b0;
    wait_idle();
    check_all(tag);
  endtask

  // monitor: compare each strobe against the scoreboard
  always @(negedge clk) begin
    if (rst_n && upd) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 unexpected strobe: actual=1 expected=0");
      end else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        chk("R9 strobe pitch", int'(pitch), int'(e[63:32]));
        chk("R9 strobe start", int'(start), int'(e[31:0]));
      end
    end
  end

  bit done = 1'b0;
  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 busy", int'(busy), 0);
    chk("R12 upd", int'(upd), 0);
    check_all("R12");

    wr(1, 13, "R1 raw xres");
    wr(3, 15, "R1 raw depth");
    wr(6, 77, "R1 raw xoff");
    wr(4, 3, "R1 raw vw");
    wr(0, 1, "R10 enable");
    wr(1, 64, "R4 raise vw");
    wr(3, 32, "R5 depth32");
    wr(2, 40, "R6 clamp lines");
    wr(3, 7, "R2 bad depth");
    wr(2, 100, "R6 clamp maxy");
    wr(2, 0, "R6 zero yres");
    wr(2, 100, "R6 clamp again");
    wr(4, 100, "R4 vw clamp");
    wr(4, 29, "R4 vw raise");
    wr(1, 30, "R3 round");
    wr(1, 0, "R3 zero");
    wr(1, 1000, "R3 clamp");
    wr(6, 100, "R7 xoff clamp");
    wr(7, 20, "R8 drop yoff");
    wr(7, 60, "R7 yoff clamp");
    wr(7, 10, "R8 fits");
    wr(3, 16, "R8 drop both");
    wr(3, 4, "R2 depth4");
    wr(6, 5, "R8 odd xoff");
    wr(7, 3, "R8 start");
    wr(3, 24, "R5 depth24");
    wr(3, 15, "R2 depth15");
    wr(5, 999, "R5 vh ignored");
    wr(0, 1, "R10 re-enable");
    wr_busy(2, 5, 40, "R11");
    wr(0, 0, "R10 disable");
    wr(1, 13, "R1 raw again");
    wr(7, 200, "R1 raw yoff");
    wr(0, 1, "R10 enable again");
    repeat (4) @(negedge clk);
    chk("R9 queue drained", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule